// File: doc/BRIEF.md
# Serial ADC Control Sequencer

This block is the digital half of an 8-bit successive-approximation converter with a serial readout. It has one free-running system clock. A host drives an active-low select line and a slow serial clock, and both reach the block asynchronously. On each access the block shifts out the last finished result, MSB first, on a data pin. It tells the analog front end when to track the input and when to freeze it. It then runs the bit-by-bit search against an external comparator.

The host selects the block and reads eight bits. The eighth falling serial edge freezes the input and starts a fixed window of hold and conversion cycles. A new access can cut that window short: either a fresh select after a deselect, or a complete new eight-edge burst. In both cases the conversion in flight is dropped and the last finished result stays in place. The select line may also stay low across many conversions in a row. A real three-state pin is modelled by the data line plus an enable.

Top module: `serial_adc_ctrl`

## Requirements
- R1: While reset is low, dout_oe_o, sample_o, hold_o and convert_o are 0 and the result register is cleared. The first access after reset shifts out 0x00.
- R2: dout_oe_o is 1 only while the select is recognised and cs_n_in is low. It drops in the same cycle that cs_n_in goes high.
- R3: The select counts as asserted only after the synchronised cs_n_in has stayed low for CS_QUAL (3) system clocks in a row. A low pulse of one or two clocks never raises dout_oe_o.
- R4: When the select is recognised, dout_o carries bit 7 of the stored result. Each of the next seven serial-clock falling edges moves the next lower bit onto dout_o, so bits 7 down to 0 appear in that order.
- R5: Serial-clock edges while the select is not recognised have no effect. No sample, hold or conversion occurs, and the stored result is unchanged.
- R6: sample_o rises after the 4th serial falling edge of an access and stays high until the 8th. After edges 1 to 3 it is 0.
- R7: The 8th falling edge clears sample_o and starts the window. hold_o is high for exactly HOLD_CYC (4) clocks, then convert_o is high for exactly WIDTH*STEP_CYC (32) clocks.
- R8: The conversion decides bit 7 first and spends STEP_CYC clocks on each bit. trial_o shows the trial code, and the trial bit is kept when cmp_in is 1 in the last clock of its step. With cmp_in = (input >= trial_o), the result equals the input code for every code from 0 to 255.
- R9: The stored result changes only when a full window ends without abort. With the select held low, the next access then reads the new value.
- R10: A fresh recognised select during the window aborts it, and the stored result keeps its earlier value.
- R11: A complete new eight-edge access during the window aborts it and restarts the window. That access shifts out the earlier finished result, and the aborted value is never stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n_in | input | 1 | Asynchronous active-low select |
| sclk_in | input | 1 | Asynchronous serial clock, falling edges active |
| cmp_in | input | 1 | Comparator decision: 1 when input is at or above trial_o |
| dout_o | output | 1 | Serial result bit |
| dout_oe_o | output | 1 | Output enable standing in for a three-state driver |
| sample_o | output | 1 | Track strobe to the sample-and-hold |
| hold_o | output | 1 | Freeze strobe for the hold phase |
| convert_o | output | 1 | High during the bit-search cycles |
| trial_o | output | 8 | Current trial code to the comparison network |

## Verification
The hardest case to reach is an abort by a second eight-edge burst. That burst has to finish inside a 36-clock window, which even a fast serial clock only just manages. A conversion that finished would also look the same at the pins, because the burst shifts out the older value in either case. The bench sends two bursts back to back at a serial half-period of two system clocks. It then aborts the restarted window with a deselect and reselect. The result read next can only equal the value stored before both bursts if the first window was truly dropped.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_CONV = 2'd2
  } phase_e;
endpackage

// File: rtl/adc_sync_edge.sv
// Multi-stage synchroniser with falling-edge detect on the synchronised level.
module adc_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      last_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/adc_cs_qual.sv
// Select qualifier: synchronised select must stay low QUAL cycles in a row.
module adc_cs_qual #(
  parameter int QUAL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_lvl_i,
  output logic act_o,
  output logic recog_o
);
  localparam int QW = $clog2(QUAL + 1);

  logic [QW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cs_lvl_i)
      cnt_d = '0;
    else if (cnt_q != QW'(QUAL))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign act_o   = (cnt_q == QW'(QUAL));
  assign recog_o = ~cs_lvl_i & (cnt_q == QW'(QUAL - 1));
endmodule

// File: rtl/adc_sar_core.sv
// Hold / convert timing and successive-approximation register.
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int W    = 8,
  parameter int HOLD = 4,
  parameter int STEP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         abort_i,
  input  logic         cmp_i,
  output logic         hold_o,
  output logic         conv_o,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] res_o,
  output logic [W-1:0] new_res_o,
  output logic         done_o
);
  localparam int TMAX = (HOLD > STEP) ? HOLD : STEP;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int BW   = (W > 1) ? $clog2(W) : 1;

  phase_e         ph_q, ph_d;
  logic [TW-1:0]  tcnt_q, tcnt_d;
  logic [BW-1:0]  bidx_q, bidx_d;
  logic [W-1:0]   sar_q, sar_d, sar_dec;
  logic [W-1:0]   res_q, res_d;
  logic           done;

  // Decision at the end of a step: keep or clear the trial bit, set the next.
  always_comb begin
    sar_dec = sar_q;
    if (!cmp_i) sar_dec[bidx_q] = 1'b0;
    if (bidx_q != '0) sar_dec[bidx_q - 1'b1] = 1'b1;
  end

  always_comb begin
    ph_d   = ph_q;
    tcnt_d = tcnt_q;
    bidx_d = bidx_q;
    sar_d  = sar_q;
    res_d  = res_q;
    done   = 1'b0;
    if (abort_i) begin
      ph_d   = PH_IDLE;
      tcnt_d = '0;
    end else if (start_i) begin
      ph_d   = PH_HOLD;
      tcnt_d = '0;
    end else begin
      unique case (ph_q)
        PH_HOLD: begin
          if (tcnt_q == TW'(HOLD - 1)) begin
            ph_d   = PH_CONV;
            tcnt_d = '0;
            bidx_d = BW'(W - 1);
            sar_d  = {1'b1, {(W-1){1'b0}}};
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        PH_CONV: begin
          if (tcnt_q == TW'(STEP - 1)) begin
            tcnt_d = '0;
            sar_d  = sar_dec;
            if (bidx_q == '0) begin
              done  = 1'b1;
              res_d = sar_dec;
              ph_d  = PH_IDLE;
            end else begin
              bidx_d = bidx_q - 1'b1;
            end
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      sar_q  <= '0;
      res_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      tcnt_q <= tcnt_d;
      bidx_q <= bidx_d;
      sar_q  <= sar_d;
      if (done) res_q <= res_d;
    end
  end

  assign hold_o    = (ph_q == PH_HOLD);
  assign conv_o    = (ph_q == PH_CONV);
  assign trial_o   = sar_q;
  assign res_o     = res_q;
  assign new_res_o = sar_dec;
  assign done_o    = done;
endmodule

// File: rtl/serial_adc_ctrl.sv
module serial_adc_ctrl #(
  parameter int WIDTH       = 8,
  parameter int HOLD_CYC    = 4,
  parameter int STEP_CYC    = 4,
  parameter int CS_QUAL     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_in,
  input  logic             sclk_in,
  input  logic             cmp_in,
  output logic             dout_o,
  output logic             dout_oe_o,
  output logic             sample_o,
  output logic             hold_o,
  output logic             convert_o,
  output logic [WIDTH-1:0] trial_o
);
  localparam int SAMPLE_EDGE = WIDTH / 2;
  localparam int EW          = $clog2(WIDTH);

  logic             cs_lvl, cs_fall_unused;
  logic             sclk_lvl, sclk_fall;
  logic             cs_act, cs_recog;
  logic             fall_ok, conv_start, conv_done;
  logic [WIDTH-1:0] res_q, new_res;

  logic [WIDTH-1:0] shreg_q, shreg_d;
  logic [EW-1:0]    ecnt_q, ecnt_d;
  logic             samp_q, samp_d;

  adc_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cs_n_in),
    .level_o(cs_lvl), .fall_o(cs_fall_unused)
  );

  adc_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sclk_in),
    .level_o(sclk_lvl), .fall_o(sclk_fall)
  );

  adc_cs_qual #(.QUAL(CS_QUAL)) u_qual (
    .clk(clk), .rst_n(rst_n), .cs_lvl_i(cs_lvl),
    .act_o(cs_act), .recog_o(cs_recog)
  );

  assign fall_ok    = sclk_fall & cs_act & ~cs_lvl;
  assign conv_start = fall_ok & (ecnt_q == EW'(WIDTH - 1));

  adc_sar_core #(.W(WIDTH), .HOLD(HOLD_CYC), .STEP(STEP_CYC)) u_core (
    .clk(clk), .rst_n(rst_n),
    .start_i(conv_start), .abort_i(cs_recog), .cmp_i(cmp_in),
    .hold_o(hold_o), .conv_o(convert_o), .trial_o(trial_o),
    .res_o(res_q), .new_res_o(new_res), .done_o(conv_done)
  );

  // Output shifter and access edge counter.
  always_comb begin
    shreg_d = shreg_q;
    ecnt_d  = ecnt_q;
    samp_d  = samp_q;
    if (cs_recog) begin
      shreg_d = res_q;
      ecnt_d  = '0;
      samp_d  = 1'b0;
    end else if (!cs_act) begin
      ecnt_d = '0;
      samp_d = 1'b0;
    end else if (fall_ok) begin
      if (ecnt_q == EW'(WIDTH - 1)) begin
        ecnt_d  = '0;
        samp_d  = 1'b0;
        shreg_d = res_q;
      end else begin
        ecnt_d  = ecnt_q + 1'b1;
        shreg_d = {shreg_q[WIDTH-2:0], 1'b0};
        if (ecnt_q == EW'(SAMPLE_EDGE - 1)) samp_d = 1'b1;
      end
    end else if (conv_done && ecnt_q == '0) begin
      shreg_d = new_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      ecnt_q  <= '0;
      samp_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      ecnt_q  <= ecnt_d;
      samp_q  <= samp_d;
    end
  end

  assign dout_o    = shreg_q[WIDTH-1];
  assign dout_oe_o = cs_act & ~cs_n_in;
  assign sample_o  = samp_q;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_in,
  input logic             dout_oe,
  input logic             sample,
  input logic             hold,
  input logic             conv,
  input logic             fall_ok,
  input logic             cs_recog,
  input logic             done,
  input logic [WIDTH-1:0] res,
  input logic [WIDTH-1:0] new_res
);
  a_r2_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_in |-> !dout_oe);

  a_r6_sample_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample) |-> $past(fall_ok));

  a_r7_hold_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(sample));

  a_r7_convert_follows_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (conv || $past(cs_recog)));

  a_r9_result_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(res));

  a_r9_result_takes_decision: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (res == $past(new_res)));

  a_r10_abort_ends_window: assert property (@(posedge clk) disable iff (!rst_n)
    cs_recog |=> (!hold && !conv));
endmodule

bind serial_adc_ctrl adc_seq_checker #(.WIDTH(WIDTH)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .dout_oe(dout_oe_o),
  .sample(sample_o), .hold(hold_o), .conv(convert_o), .fall_ok(fall_ok),
  .cs_recog(cs_recog), .done(conv_done), .res(res_q), .new_res(new_res)
);

// File: tb/serial_adc_ctrl_test.sv
module serial_adc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n, cs_n, sclk;
  logic [7:0] vin;
  logic       cmp, dout, oe, sample, hold, conv;
  logic [7:0] trial;

  int nchk = 0;
  int nfail = 0;
  int hold_tot = 0;
  int conv_tot = 0;
  int oe_tot = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign cmp = (vin >= trial);

  serial_adc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sclk), .cmp_in(cmp),
    .dout_o(dout), .dout_oe_o(oe), .sample_o(sample), .hold_o(hold),
    .convert_o(conv), .trial_o(trial)
  );

  always @(negedge clk) begin
    if (hold) hold_tot++;
    if (conv) conv_tot++;
    if (oe)   oe_tot++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic select_cs();
    cs_n = 1'b0;
    step(10);
  endtask

  task automatic deselect_cs();
    cs_n = 1'b1;
    step(6);
  endtask

  task automatic access(input int half, output logic [7:0] val, output logic [7:0] smp);
    val = '0;
    smp = '0;
    val[7] = dout;
    for (int k = 1; k <= 8; k++) begin
      sclk = 1'b0;
      step(half);
      sclk = 1'b1;
      step(half);
      if (k < 8) begin
        val[7-k] = dout;
        smp[k]   = sample;
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] got, smp, prev;
    int h0, c0, o0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; vin = 8'h00;
    step(5);
    // R1: outputs idle in reset
    chk("R1 oe", oe, 0); chk("R1 sample", sample, 0);
    chk("R1 hold", hold, 0); chk("R1 convert", conv, 0);
    rst_n = 1'b1;
    step(3);
    select_cs();
    chk("R2 oe after select", oe, 1);
    prev = 8'h00;
    // Exhaustive sweep: every access reads the previous conversion (R1, R4, R8, R9)
    for (int v = 0; v < 256; v++) begin
      vin = 8'(v);
      h0 = hold_tot; c0 = conv_tot;
      access(5, got, smp);
      chk((v == 0) ? "R1 first read" : "R8 result", got, prev);
      if (v == 0) begin
        for (int k = 1; k < 8; k++) chk("R6 sample after edge", smp[k], (k >= 4) ? 1 : 0);
      end
      step(45);
      chk("R7 hold cycles", hold_tot - h0, 4);
      chk("R7 convert cycles", conv_tot - c0, 32);
      if (v == 1) chk("R7 sample cleared", sample, 0);
      prev = 8'(v);
      if (v[0]) begin
        deselect_cs();
        select_cs();
      end else if (v == 2) begin
        chk("R9 back-to-back msb", dout, prev[7]);
      end
    end

    // R2: enable drops at once on deselect
    cs_n = 1'b1;
    #1;
    chk("R2 oe immediate off", oe, 0);
    step(8);

    // R3: short select pulses are filtered
    o0 = oe_tot;
    cs_n = 1'b0; step(1); cs_n = 1'b1; step(8);
    cs_n = 1'b0; step(2); cs_n = 1'b1; step(8);
    chk("R3 glitch ignored", oe_tot - o0, 0);

    // R5: serial clock ignored while deselected
    h0 = hold_tot; c0 = conv_tot;
    vin = 8'h77;
    access(5, got, smp);
    step(45);
    chk("R5 no hold", hold_tot - h0, 0);
    chk("R5 no convert", conv_tot - c0, 0);
    select_cs();
    chk("R4 msb on select", dout, prev[7]);
    vin = 8'h3C;
    access(5, got, smp);
    chk("R5 result unchanged", got, prev);
    step(45);
    prev = 8'h3C;

    // R10: reselect during the window aborts it
    vin = 8'hA5;
    access(5, got, smp);
    chk("R10 read before abort", got, prev);
    step(3);
    cs_n = 1'b1; step(4);
    select_cs();
    step(45);
    vin = 8'h11;
    access(5, got, smp);
    chk("R10 aborted value absent", got, prev);
    step(45);
    prev = 8'h11;

    // R11: a second fast access aborts and restarts; then abort that one too
    vin = 8'h5A;
    access(2, got, smp);
    chk("R11 fast read", got, prev);
    access(2, got, smp);
    chk("R11 burst shows earlier result", got, prev);
    cs_n = 1'b1; step(4);
    select_cs();
    step(45);
    vin = 8'hC3;
    access(5, got, smp);
    chk("R11 first window dropped", got, prev);
    step(45);
    access(5, got, smp);
    chk("R8 final conversion", got, 8'hC3);
    step(45);
    summary();
  end
endmodule